// File: doc/BRIEF.md
# DMA Buffer-to-Burst Transfer Sequencer

This block is the address and length engine of one DMA channel endpoint. Software programs a start address, an item width, a buffer length in items, a buffer count and a chunk length, then pulses a start strobe. The sequencer turns the whole transfer into a stream of bus access descriptors. Each descriptor carries an address, a beat count and a flag that marks a single access. A bus master takes each descriptor when it raises its ready line.

For a memory endpoint, every buffer goes straight to bus accesses. The sequencer issues full incrementing bursts of up to the maximum beat count, then a remainder. For a peripheral endpoint, nothing moves until the peripheral asks. A single request yields a one-item transaction. A chunk request yields a transaction of the programmed chunk length, which is then cut into bursts in the same way as a memory buffer.

Addresses run on without a gap across bursts and buffers. After the last buffer of the transfer, the channel disables itself and pulses an interrupt.

Top module: `dma_burst_seq`

## Requirements
- R1: With cfg_periph=0, after cfg_start the block issues descriptors with no request input, beginning at cfg_addr. Every buffer of cfg_buf_len items (at least 1) is covered in full bursts of 16 beats, followed by the remainder.
- R2: Every descriptor has between 1 and 16 beats. Each accepted descriptor moves the next address forward by beats times 2^cfg_width bytes (cfg_width 0=1, 1=2, 2=4 bytes). Addresses stay contiguous across bursts and across buffers.
- R3: A remainder shorter than 16 beats is handled according to cfg_tail_single. With 0 it goes out as one shorter burst; with 1 it goes out as one-beat accesses. desc_single=1 exactly when desc_beats=1.
- R4: With cfg_periph=1, no descriptor is issued until a request is seen. An accepted chunk request covers cfg_chunk_len items (at least 1), split into bursts of at most 16 beats under the R3 remainder rule.
- R5: An accepted single request produces exactly one descriptor with desc_beats=1 and desc_single=1.
- R6: The peripheral request rule depends on the items left in the buffer. If both requests are high and at least cfg_chunk_len items remain, the chunk is taken. The single request wins only when fewer than cfg_chunk_len items remain. A chunk request alone in that case is ignored.
- R7: The transfer ends after cfg_num_bufs buffers; a value of 0 counts as 1. The end address equals cfg_addr plus buffers times length times item size.
- R8: In the cycle after the last descriptor is accepted, ch_enable reads 0 and irq_done is 1 for exactly one cycle. After that, no further descriptor is issued.
- R9: While desc_valid=1 and bus_ready=0, desc_valid, desc_addr and desc_beats hold their values.
- R10: After rst, ch_enable, desc_valid and irq_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start strobe, accepted when channel is disabled |
| cfg_addr | input | ADDR_W | First byte address of the transfer |
| cfg_buf_len | input | LEN_W | Items per buffer |
| cfg_num_bufs | input | NB_W | Buffers per transfer |
| cfg_chunk_len | input | LEN_W | Items per chunk transaction |
| cfg_width | input | 2 | Item size code, bytes = 2^code |
| cfg_periph | input | 1 | 1 = peripheral endpoint, 0 = memory |
| cfg_tail_single | input | 1 | 1 = remainder as single accesses |
| req_single | input | 1 | Peripheral single request |
| req_chunk | input | 1 | Peripheral chunk request |
| bus_ready | input | 1 | Bus master takes the current descriptor |
| ch_enable | output | 1 | Channel busy |
| desc_valid | output | 1 | Descriptor present |
| desc_addr | output | ADDR_W | Descriptor start address |
| desc_beats | output | BEAT_W | Descriptor beat count |
| desc_single | output | 1 | Descriptor is a single access |
| irq_done | output | 1 | One-cycle completion pulse |

## Verification
Memory transfers are run with buffer lengths that are an exact multiple of 16, one above a multiple, and well above a multiple. Each is run under both remainder modes and with several buffer counts and item sizes. The descriptor count, the single count and the end address show which remainder rule was applied and whether buffer rollover kept the addresses contiguous. Peripheral transfers hold both requests high with chunk lengths below and above 16. The size of the first descriptor shows that the chunk won, and the trailing singles show where the single request took over. Directed runs cover a lone chunk request that cannot fit and is held off, a lone single request, and a stalled bus master.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_PLAN  = 2'd2,
    ST_ISSUE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dma_beat_split.sv
// Picks the size of the next bus access from the span still to cover.
module dma_beat_split #(
  parameter int LEN_W     = 16,
  parameter int MAX_BEATS = 16,
  localparam int BEAT_W   = $clog2(MAX_BEATS + 1)
) (
  input  logic [LEN_W-1:0]  span,
  input  logic              tail_single,
  output logic [BEAT_W-1:0] beats,
  output logic              single
);
  always_comb begin
    if (span >= LEN_W'(MAX_BEATS))
      beats = BEAT_W'(MAX_BEATS);
    else if (tail_single)
      beats = BEAT_W'(1);
    else
      beats = span[BEAT_W-1:0];
    single = (beats == BEAT_W'(1));
  end
endmodule

// File: rtl/dma_xact_arb.sv
// Chooses between peripheral chunk and single requests.
module dma_xact_arb #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] remaining,
  input  logic [LEN_W-1:0] chunk_len,
  input  logic             req_single,
  input  logic             req_chunk,
  output logic             take,
  output logic [LEN_W-1:0] xact_len
);
  logic chunk_fits;

  always_comb begin
    chunk_fits = (chunk_len != '0) && (remaining >= chunk_len);
    take       = 1'b0;
    xact_len   = LEN_W'(1);
    if (req_chunk && chunk_fits) begin
      take     = 1'b1;
      xact_len = chunk_len;
    end else if (req_single) begin
      take     = 1'b1;
      xact_len = LEN_W'(1);
    end
  end
endmodule

// File: rtl/dma_buf_tracker.sv
// Counts finished buffers of the running transfer.
module dma_buf_tracker #(
  parameter int NB_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            buf_done,
  input  logic [NB_W-1:0] num_bufs,
  output logic            last_buf
);
  logic [NB_W-1:0] done_cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)
      done_cnt <= '0;
    else if (buf_done && !last_buf)
      done_cnt <= done_cnt + NB_W'(1);
  end

  assign last_buf = ({1'b0, done_cnt} + (NB_W+1)'(1)) >= {1'b0, num_bufs};

  // R7
  buf_count_chk: assert property (@(posedge clk) disable iff (rst)
    (done_cnt == '0) || (done_cnt < num_bufs));
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int NB_W      = 8,
  parameter int MAX_BEATS = 16,
  localparam int BEAT_W   = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_start,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]  cfg_buf_len,
  input  logic [NB_W-1:0]   cfg_num_bufs,
  input  logic [LEN_W-1:0]  cfg_chunk_len,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_periph,
  input  logic              cfg_tail_single,
  input  logic              req_single,
  input  logic              req_chunk,
  input  logic              bus_ready,
  output logic              ch_enable,
  output logic              desc_valid,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [BEAT_W-1:0] desc_beats,
  output logic              desc_single,
  output logic              irq_done
);
  seq_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, xact_q, buf_len_q, chunk_q;
  logic [NB_W-1:0]   nbufs_q;
  logic [1:0]        width_q;
  logic              periph_q, tail_q;

  logic [LEN_W-1:0]  span, rem_nx, xact_nx, arb_len;
  logic [BEAT_W-1:0] plan_beats;
  logic              plan_single, arb_take, last_buf, buf_done, accept, clear;
  logic [ADDR_W-1:0] step;

  assign span    = periph_q ? xact_q : rem_q;
  assign accept  = (state == ST_ISSUE) && bus_ready;
  assign rem_nx  = rem_q - LEN_W'(desc_beats);
  assign xact_nx = xact_q - LEN_W'(desc_beats);
  assign step    = ADDR_W'(desc_beats) << width_q;
  assign buf_done = accept && (rem_nx == '0);
  assign clear   = (state == ST_IDLE) && cfg_start;

  dma_beat_split #(.LEN_W(LEN_W), .MAX_BEATS(MAX_BEATS)) u_split (
    .span(span), .tail_single(tail_q), .beats(plan_beats), .single(plan_single)
  );

  dma_xact_arb #(.LEN_W(LEN_W)) u_arb (
    .remaining(rem_q), .chunk_len(chunk_q), .req_single(req_single),
    .req_chunk(req_chunk), .take(arb_take), .xact_len(arb_len)
  );

  dma_buf_tracker #(.NB_W(NB_W)) u_bufs (
    .clk(clk), .rst(rst), .clear(clear), .buf_done(buf_done),
    .num_bufs(nbufs_q), .last_buf(last_buf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      addr_q      <= '0;
      rem_q       <= '0;
      xact_q      <= '0;
      buf_len_q   <= '0;
      chunk_q     <= '0;
      nbufs_q     <= '0;
      width_q     <= '0;
      periph_q    <= 1'b0;
      tail_q      <= 1'b0;
      ch_enable   <= 1'b0;
      desc_valid  <= 1'b0;
      desc_addr   <= '0;
      desc_beats  <= '0;
      desc_single <= 1'b0;
      irq_done    <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cfg_start) begin
            addr_q    <= cfg_addr;
            rem_q     <= cfg_buf_len;
            buf_len_q <= cfg_buf_len;
            chunk_q   <= cfg_chunk_len;
            nbufs_q   <= cfg_num_bufs;
            width_q   <= cfg_width;
            periph_q  <= cfg_periph;
            tail_q    <= cfg_tail_single;
            ch_enable <= 1'b1;
            state     <= cfg_periph ? ST_WAIT : ST_PLAN;
          end
        end
        ST_WAIT: begin
          if (arb_take) begin
            xact_q <= arb_len;
            state  <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          desc_valid  <= 1'b1;
          desc_addr   <= addr_q;
          desc_beats  <= plan_beats;
          desc_single <= plan_single;
          state       <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (bus_ready) begin
            desc_valid <= 1'b0;
            addr_q     <= addr_q + step;
            rem_q      <= rem_nx;
            xact_q     <= xact_nx;
            if (rem_nx == '0) begin
              if (last_buf) begin
                ch_enable <= 1'b0;
                irq_done  <= 1'b1;
                state     <= ST_IDLE;
              end else begin
                rem_q <= buf_len_q;
                state <= periph_q ? ST_WAIT : ST_PLAN;
              end
            end else if (periph_q && xact_nx == '0) begin
              state <= ST_WAIT;
            end else begin
              state <= ST_PLAN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  beats_range_chk: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> (desc_beats != '0) && (desc_beats <= BEAT_W'(MAX_BEATS)));

  // R9
  desc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !bus_ready) |=> desc_valid && $stable(desc_addr) && $stable(desc_beats));

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> !ch_enable && !desc_valid);

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done);
endmodule

// File: tb/dma_burst_seq_bench.sv
module dma_burst_seq_bench;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int NB_W   = 8;
  localparam int BEAT_W = 5;
  localparam logic [31:0] BASE = 32'h1000;

  typedef struct packed {
    logic        periph;
    logic        tail;
    logic [15:0] len;
    logic [7:0]  nb;
    logic [15:0] cl;
    logic [1:0]  w;
    logic [31:0] ndesc;
    logic [31:0] nsingle;
    logic [31:0] end_addr;
    logic [31:0] first_beats;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'd40, 8'd1, 16'd8,  2'd2, 32'd3,  32'd0, 32'h10A0, 32'd16},
    '{1'b0, 1'b1, 16'd20, 8'd2, 16'd8,  2'd0, 32'd10, 32'd8, 32'h1028, 32'd16},
    '{1'b0, 1'b0, 16'd17, 8'd3, 16'd8,  2'd1, 32'd6,  32'd3, 32'h1066, 32'd16},
    '{1'b0, 1'b0, 16'd16, 8'd0, 16'd8,  2'd2, 32'd1,  32'd0, 32'h1040, 32'd16},
    '{1'b1, 1'b0, 16'd20, 8'd1, 16'd8,  2'd0, 32'd6,  32'd4, 32'h1014, 32'd8},
    '{1'b1, 1'b1, 16'd40, 8'd1, 16'd20, 2'd2, 32'd10, 32'd8, 32'h10A0, 32'd16}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_start = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = BASE;
  logic [LEN_W-1:0]  cfg_buf_len = '0;
  logic [NB_W-1:0]   cfg_num_bufs = '0;
  logic [LEN_W-1:0]  cfg_chunk_len = '0;
  logic [1:0]        cfg_width = '0;
  logic cfg_periph = 1'b0, cfg_tail_single = 1'b0;
  logic req_single = 1'b0, req_chunk = 1'b0, bus_ready = 1'b0;
  logic ch_enable, desc_valid, desc_single, irq_done;
  logic [ADDR_W-1:0] desc_addr;
  logic [BEAT_W-1:0] desc_beats;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  dma_burst_seq u_dma_burst_seq (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_addr(cfg_addr),
    .cfg_buf_len(cfg_buf_len), .cfg_num_bufs(cfg_num_bufs),
    .cfg_chunk_len(cfg_chunk_len), .cfg_width(cfg_width),
    .cfg_periph(cfg_periph), .cfg_tail_single(cfg_tail_single),
    .req_single(req_single), .req_chunk(req_chunk), .bus_ready(bus_ready),
    .ch_enable(ch_enable), .desc_valid(desc_valid), .desc_addr(desc_addr),
    .desc_beats(desc_beats), .desc_single(desc_single), .irq_done(irq_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Starts a transfer and watches it to the end; called at a negedge.
  task automatic run_xfer(input logic periph, input logic tail, input logic [15:0] len,
                          input logic [7:0] nb, input logic [15:0] cl, input logic [1:0] w,
                          input int ready_mode,
                          output int ndesc, output int nsingle, output int first_beats,
                          output logic [31:0] end_addr, output int bad, output int en_after,
                          output int irqs);
    logic [31:0] exp_addr, hold_addr;
    int stalled;
    ndesc = 0; nsingle = 0; first_beats = -1; bad = 0; en_after = 1; irqs = 0;
    stalled = 0; hold_addr = '0;
    cfg_periph = periph; cfg_tail_single = tail; cfg_buf_len = len;
    cfg_num_bufs = nb; cfg_chunk_len = cl; cfg_width = w; cfg_addr = BASE;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    exp_addr = BASE;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      bus_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (stalled != 0 && (!desc_valid || desc_addr !== hold_addr)) bad++;
      stalled = 0;
      if (irq_done) begin
        irqs++;
        en_after = ch_enable;
        break;
      end
      if (desc_valid) begin
        if (first_beats < 0) first_beats = desc_beats;
        if (bus_ready) begin
          if (desc_addr !== exp_addr) bad++;
          if (desc_beats == 0 || desc_beats > 16) bad++;
          if (desc_single !== (desc_beats == 1)) bad++;
          ndesc++;
          if (desc_single) nsingle++;
          exp_addr = exp_addr + (32'(desc_beats) << w);
        end else begin
          stalled = 1;
          hold_addr = desc_addr;
        end
      end
      @(negedge clk);
    end
    bus_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (irq_done) irqs++;
      if (desc_valid) bad++;
    end
    end_addr = exp_addr;
  endtask

  initial begin
    int nd, ns, fb, bad, en, irqs;
    logic [31:0] ea;
    int seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ch_enable after reset", 32'(ch_enable), 32'd0);
    chk("R10 desc_valid after reset", 32'(desc_valid), 32'd0);
    chk("R10 irq_done after reset", 32'(irq_done), 32'd0);

    for (int i = 0; i < NV; i++) begin
      req_single = VECS[i].periph;
      req_chunk  = VECS[i].periph;
      run_xfer(VECS[i].periph, VECS[i].tail, VECS[i].len, VECS[i].nb, VECS[i].cl,
               VECS[i].w, i % 2, nd, ns, fb, ea, bad, en, irqs);
      req_single = 1'b0;
      req_chunk  = 1'b0;
      chk(VECS[i].periph ? "R4 descriptor count" : "R1 descriptor count", 32'(nd), VECS[i].ndesc);
      chk("R3 single access count", 32'(ns), VECS[i].nsingle);
      chk("R7 end address", ea, VECS[i].end_addr);
      chk(VECS[i].periph ? "R6 first descriptor beats" : "R1 first descriptor beats",
          32'(fb), VECS[i].first_beats);
      chk("R2 contiguity and hold", 32'(bad), 32'd0);
      chk("R8 enable low after done", 32'(en), 32'd0);
      chk("R8 single irq pulse", 32'(irqs), 32'd1);
    end

    // R6: a chunk request that does not fit is ignored; then singles finish the buffer
    cfg_periph = 1'b1; cfg_tail_single = 1'b0; cfg_buf_len = 16'd4;
    cfg_num_bufs = 8'd1; cfg_chunk_len = 16'd8; cfg_width = 2'd0;
    req_chunk = 1'b1; req_single = 1'b0; bus_ready = 1'b1;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (desc_valid) seen++;
    end
    chk("R6 lone oversize chunk ignored", 32'(seen), 32'd0);
    chk("R4 channel still enabled while waiting", 32'(ch_enable), 32'd1);
    req_single = 1'b1;
    seen = 0;
    for (int k = 0; k < 100 && ch_enable; k++) begin
      @(negedge clk);
      if (desc_valid && bus_ready) begin
        seen++;
        if (desc_beats !== 5'd1 || !desc_single) chk("R5 single beats", 32'(desc_beats), 32'd1);
      end
    end
    chk("R5 singles after chunk refused", 32'(seen), 32'd4);
    req_single = 1'b0; req_chunk = 1'b0; bus_ready = 1'b0;
    repeat (2) @(negedge clk);

    // R5: single requests alone with room for a chunk still give one-beat accesses
    req_single = 1'b1;
    run_xfer(1'b1, 1'b0, 16'd3, 8'd1, 16'd2, 2'd1, 0, nd, ns, fb, ea, bad, en, irqs);
    req_single = 1'b0;
    chk("R5 lone single descriptor count", 32'(nd), 32'd3);
    chk("R5 lone single flag count", 32'(ns), 32'd3);
    chk("R5 lone single end address", ea, 32'h1006);

    // R9: long stall of the bus master keeps the descriptor steady
    cfg_periph = 1'b0; cfg_tail_single = 1'b0; cfg_buf_len = 16'd40;
    cfg_num_bufs = 8'd1; cfg_width = 2'd2; bus_ready = 1'b0;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 descriptor up two cycles after start", 32'(desc_valid), 32'd1);
    ea = desc_addr;
    repeat (6) @(negedge clk);
    chk("R9 valid held in stall", 32'(desc_valid), 32'd1);
    chk("R9 address held in stall", desc_addr, ea);
    chk("R9 beats held in stall", 32'(desc_beats), 32'd16);
    bus_ready = 1'b1;
    for (int k = 0; k < 50 && !irq_done; k++) @(negedge clk);
    chk("R8 irq after stalled run", 32'(irq_done), 32'd1);
    chk("R8 enable low after stalled run", 32'(ch_enable), 32'd0);
    bus_ready = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule